// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block sets the bridge state for each phase of a stepper-motor current regulator. An external oscillator supplies a one-cycle tick. Four ticks make one chopping period. For each phase, a comparator flag that is already synchronized reports whether the sensed winding current has reached its target. From these inputs the block picks one of three bridge states for each phase: charge, slow decay or fast decay. A fourth state, off, is used while the block is disabled.

Every period opens with a short charge probe, and the comparator is not read during the probe. Once the target is reached the bridge drops to slow decay. A two-bit decay setting chooses how much of the end of the period runs in fast decay. If the current is still at or above target when a period ends, the next period leaves charge as soon as its probe finishes. A step event restarts the chopping period on the next oscillator tick, so the new set-point is probed without waiting for the current period to end.

Top module: `chop_controller`

## Requirements
- R1: Each phase has a 2-bit mode code: 00 off, 01 charge, 10 slow decay, 11 fast decay. Phase p uses bits [2p+1:2p]. The code is off after reset and whenever `enable` is low, whatever the other inputs do.
- R2: A chopping period lasts four oscillator ticks, indexed 0 to 3. The index advances only on a tick. The tick that arrives while the index is 3 begins a new period, and every phase enters charge on that tick.
- R3: The decay setting picks the fast-decay zone at the end of the period: 00 means none, 01 means tick 3, 10 means ticks 2 and 3, and 11 means all four ticks.
- R4: Once the probe has finished, a phase in charge whose comparator flag is high moves to slow decay when outside the fast zone. With setting 00, slow decay then holds until the period ends.
- R5: A phase in slow decay moves to fast decay when the index enters the fast zone. Fast decay then holds until the period ends.
- R6: If the target is reached while inside the fast zone, the phase goes from charge straight to fast decay. This includes every tick under setting 11.
- R7: Each period begins with a charge probe lasting at least PROBE_CYCLES clocks. The comparator flag has no effect during the probe.
- R8: If a phase's comparator flag is high on the tick that starts a period, that phase leaves charge as soon as its probe ends, even if the flag is then low.
- R9: A step event starts a new period, with index 0 and a fresh probe, at the next oscillator tick. The mode does not change between the step and that tick.
- R10: When `enable` goes high again, the mode stays off until the first tick, and that tick starts a fresh period at index 0.
- R11: Each phase follows only its own comparator flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low forces all phases off and holds the period counter cleared |
| osc_tick | input | 1 | One-clock pulse from the chopping oscillator |
| step_evt | input | 1 | One-clock pulse when the current set-point steps |
| decay_sel | input | 2 | Fast-decay share: 00 none, 01 quarter, 10 half, 11 full |
| at_target | input | NUM_PHASES | Synchronized comparator flag per phase, high when current has reached target |
| bridge_mode | output | 2*NUM_PHASES | Registered mode code per phase |

## Verification
The four decay settings are each run with the target reached early in the period, which shows where the slow-to-fast switch point falls. One case reaches the target only inside the fast zone, which separates a direct charge-to-fast move from a path that goes through slow decay. A comparator flag held high across a period boundary and then dropped shows that the probe ignores the flag and that the charge skip follows from it. A step issued at tick 2 under the half setting separates a counter that restarts from one that merely wraps. Disable/re-enable, and unequal flags on the two phases, cover the remaining patterns.

// File: rtl/chop_pkg.sv
package chop_pkg;

  localparam int TICKS_PER_PERIOD = 4;
  localparam int TICK_W = $clog2(TICKS_PER_PERIOD);

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CHARGE = 2'b01,
    MODE_SLOW   = 2'b10,
    MODE_FAST   = 2'b11
  } bridge_mode_e;

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase
  import chop_pkg::*;
#(
  parameter int PROBE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              osc_tick,
  input  logic              step_evt,
  output logic              restart,
  output logic [TICK_W-1:0] tick_idx,
  output logic              probe_busy
);

  localparam int PW = $clog2(PROBE_CYCLES + 1);
  localparam logic [TICK_W-1:0] LAST_IDX = TICK_W'(TICKS_PER_PERIOD - 1);

  logic          restart_pend;
  logic [PW-1:0] probe_left;

  assign restart    = enable && osc_tick && (restart_pend || tick_idx == LAST_IDX);
  assign probe_busy = (probe_left != '0);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tick_idx     <= '0;
      restart_pend <= 1'b1;
      probe_left   <= '0;
    end else begin
      if (restart) begin
        tick_idx     <= '0;
        restart_pend <= 1'b0;
        probe_left   <= PW'(PROBE_CYCLES);
      end else begin
        if (step_evt) restart_pend <= 1'b1;
        if (osc_tick) tick_idx <= tick_idx + TICK_W'(1);
        if (probe_busy) probe_left <= probe_left - PW'(1);
      end
    end
  end

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !osc_tick) |=> $stable(tick_idx));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tick_idx == '0) && probe_busy);

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (tick_idx == '0) && !probe_busy);

endmodule

// File: rtl/chop_fast_zone.sv
module chop_fast_zone
  import chop_pkg::*;
(
  input  logic [1:0]        decay_sel,
  input  logic [TICK_W-1:0] tick_idx,
  output logic              fast_zone
);

  localparam int SW = TICK_W + 1;

  logic [SW-1:0] span;

  always_comb begin
    case (decay_sel)
      2'b01:   span = SW'(TICKS_PER_PERIOD / 4);
      2'b10:   span = SW'(TICKS_PER_PERIOD / 2);
      2'b11:   span = SW'(TICKS_PER_PERIOD);
      default: span = '0;
    endcase
  end

  assign fast_zone = ({1'b0, tick_idx} + span) >= SW'(TICKS_PER_PERIOD);

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
  import chop_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         restart,
  input  logic         probe_busy,
  input  logic         fast_zone,
  input  logic         at_target,
  output bridge_mode_e mode
);

  logic skip_charge;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      mode        <= MODE_OFF;
      skip_charge <= 1'b0;
    end else if (restart) begin
      mode        <= MODE_CHARGE;
      skip_charge <= at_target;
    end else begin
      case (mode)
        MODE_CHARGE: begin
          if (!probe_busy && (skip_charge || at_target))
            mode <= fast_zone ? MODE_FAST : MODE_SLOW;
        end
        MODE_SLOW: begin
          if (fast_zone) mode <= MODE_FAST;
        end
        default: mode <= mode;
      endcase
    end
  end

  // R1
  off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> mode == MODE_OFF);

  // R7
  probe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !restart && probe_busy && mode == MODE_CHARGE) |=> mode == MODE_CHARGE);

  // R5
  fast_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FAST) |=> mode != MODE_SLOW);

  // R3
  fast_needs_zone_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_FAST && !fast_zone) |=> mode != MODE_FAST);

  // R2
  restart_charge_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> mode == MODE_CHARGE);

endmodule

// File: rtl/chop_controller.sv
module chop_controller
  import chop_pkg::*;
#(
  parameter int NUM_PHASES   = 2,
  parameter int PROBE_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    osc_tick,
  input  logic                    step_evt,
  input  logic [1:0]              decay_sel,
  input  logic [NUM_PHASES-1:0]   at_target,
  output logic [2*NUM_PHASES-1:0] bridge_mode
);

  logic              restart;
  logic [TICK_W-1:0] tick_idx;
  logic              probe_busy;
  logic              fast_zone;

  chop_timebase #(
    .PROBE_CYCLES(PROBE_CYCLES)
  ) u_timebase (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .osc_tick   (osc_tick),
    .step_evt   (step_evt),
    .restart    (restart),
    .tick_idx   (tick_idx),
    .probe_busy (probe_busy)
  );

  chop_fast_zone u_zone (
    .decay_sel (decay_sel),
    .tick_idx  (tick_idx),
    .fast_zone (fast_zone)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    bridge_mode_e ph_mode;

    chop_phase_ctrl u_phase (
      .clk        (clk),
      .rst        (rst),
      .enable     (enable),
      .restart    (restart),
      .probe_busy (probe_busy),
      .fast_zone  (fast_zone),
      .at_target  (at_target[p]),
      .mode       (ph_mode)
    );

    assign bridge_mode[2*p +: 2] = ph_mode;
  end

endmodule

// File: tb/sim_chop_controller.sv
module sim_chop_controller;

  localparam int CLK_PERIOD = 10;
  localparam int NPH        = 2;
  localparam int PROBE      = 8;
  localparam logic [1:0] OFF = 2'b00, CHG = 2'b01, SLW = 2'b10, FST = 2'b11;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           enable = 1'b0;
  logic           osc_tick = 1'b0;
  logic           step_evt = 1'b0;
  logic [1:0]     decay_sel = 2'b00;
  logic [NPH-1:0] at_target = '0;
  logic [2*NPH-1:0] bridge_mode;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chop_controller #(.NUM_PHASES(NPH), .PROBE_CYCLES(PROBE)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .osc_tick(osc_tick),
    .step_evt(step_evt), .decay_sel(decay_sel), .at_target(at_target),
    .bridge_mode(bridge_mode)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic check(input int ph, input logic [1:0] exp, input string req);
    logic [1:0] got;
    got = bridge_mode[2*ph +: 2];
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s phase %0d: got %b expected %b", req, ph, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] dsel);
    @(negedge clk);
    rst = 1'b1; enable = 1'b1; at_target = '0; step_evt = 1'b0; decay_sel = dsel;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_reset_state();
    do_reset(2'b00);
    check(0, OFF, "R1");
    check(1, OFF, "R1");
  endtask

  task automatic t_normal();
    do_reset(2'b00);
    tick(); wait_clk(12);
    check(0, CHG, "R2");
    at_target = 2'b11; wait_clk(3);
    check(0, SLW, "R4");
    tick(); tick(); tick(); wait_clk(3);
    check(0, SLW, "R4");
  endtask

  task automatic t_quarter();
    do_reset(2'b01);
    tick(); wait_clk(12);
    at_target = 2'b11; wait_clk(3);
    check(0, SLW, "R4");
    tick(); tick(); wait_clk(3);
    check(0, SLW, "R3");
    tick(); wait_clk(3);
    check(0, FST, "R5");
  endtask

  task automatic t_half();
    do_reset(2'b10);
    tick(); wait_clk(12);
    at_target = 2'b11; wait_clk(3);
    tick(); wait_clk(3);
    check(0, SLW, "R3");
    tick(); wait_clk(3);
    check(0, FST, "R5");
  endtask

  task automatic t_full();
    do_reset(2'b11);
    tick(); wait_clk(12);
    check(0, CHG, "R6");
    at_target = 2'b11; wait_clk(3);
    check(0, FST, "R6");
  endtask

  task automatic t_late_target();
    do_reset(2'b01);
    tick(); tick(); tick(); tick(); wait_clk(12);
    check(0, CHG, "R6");
    at_target = 2'b11; wait_clk(3);
    check(0, FST, "R6");
  endtask

  task automatic t_probe_skip();
    do_reset(2'b00);
    tick(); wait_clk(12);
    at_target = 2'b11; wait_clk(3);
    tick(); tick(); tick();
    tick();
    at_target = 2'b00;
    wait_clk(2);
    check(0, CHG, "R7");
    wait_clk(12);
    check(0, SLW, "R8");
    tick(); tick(); tick(); tick(); wait_clk(12);
    check(0, CHG, "R8");
  endtask

  task automatic t_probe_ignores_flag();
    do_reset(2'b00);
    at_target = 2'b11;
    tick(); wait_clk(PROBE - 3);
    check(0, CHG, "R7");
    wait_clk(8);
    check(0, SLW, "R7");
  endtask

  task automatic t_step();
    do_reset(2'b10);
    tick(); wait_clk(12);
    at_target = 2'b11; wait_clk(3);
    tick(); tick(); wait_clk(3);
    check(0, FST, "R5");
    step_evt = 1'b1; @(negedge clk); step_evt = 1'b0;
    at_target = 2'b00; wait_clk(3);
    check(0, FST, "R9");
    tick(); wait_clk(2);
    check(0, CHG, "R9");
    wait_clk(12);
    check(0, CHG, "R9");
    at_target = 2'b11; wait_clk(3);
    tick(); wait_clk(3);
    check(0, SLW, "R9");
  endtask

  task automatic t_disable();
    do_reset(2'b11);
    tick(); wait_clk(12);
    at_target = 2'b11; wait_clk(3);
    enable = 1'b0; wait_clk(2);
    check(0, OFF, "R1");
    tick(); tick(); wait_clk(3);
    check(1, OFF, "R1");
    decay_sel = 2'b10;
    enable = 1'b1; at_target = 2'b00; wait_clk(3);
    check(0, OFF, "R10");
    tick(); wait_clk(12);
    check(0, CHG, "R10");
    at_target = 2'b11; wait_clk(3);
    tick(); wait_clk(3);
    check(0, SLW, "R10");
  endtask

  task automatic t_phases();
    do_reset(2'b00);
    tick(); wait_clk(12);
    at_target = 2'b01; wait_clk(3);
    check(0, SLW, "R11");
    check(1, CHG, "R11");
    at_target = 2'b11; wait_clk(3);
    check(1, SLW, "R11");
  endtask

  initial begin
    t_reset_state();
    t_normal();
    t_quarter();
    t_half();
    t_full();
    t_late_target();
    t_probe_skip();
    t_probe_ignores_flag();
    t_step();
    t_disable();
    t_phases();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule